// File: doc/BRIEF.md
# Dual-Source Loadable Shift Register with Held B Byte

This block is a parallel-load, serial-in, serial-out shift register for pixel serialisation. Its load value comes from one of two byte-wide ports. Port A feeds the load selector directly. Port B first passes through a transparent holding latch, so a byte can be captured ahead of time while the register is busy with other data.

On each rising clock edge the register does one of two things. It either loads the chosen byte, or it shifts one place toward the most significant stage, taking a new bit from the serial input. Only the most significant stage is visible, as the serial output. Registers can be chained to any multiple of eight bits by wiring one serial output to the next serial input.

Top module: `mlsr_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all stages are cleared, so `ser_out` is 0 after that edge. The holding latch is also cleared while `rst_n` is low.
- R2: `ser_out` is the most significant stage itself, with no further register. A change in the register is visible on `ser_out` right after the same clock edge.
- R3: With `load_n` = 0 and `sel_b` = 0 at a clock edge, the register loads `par_a`. Bit 7 of that byte appears on `ser_out`.
- R4: With `load_n` = 0 and `sel_b` = 1 at a clock edge, the register loads the byte held in the B latch.
- R5: While `b_open` = 1, the B latch is transparent and follows `par_b`. A load from B in that cycle takes the current `par_b`.
- R6: While `b_open` = 0, the B latch keeps its last value. Changes on `par_b` have no effect on any later load from B.
- R7: With `load_n` = 1 at a clock edge, every stage takes the value of its lower neighbour and stage 0 takes `ser_in`. After a load, seven shifts present bits 6 down to 0 on `ser_out`, most significant bit first.
- R8: A bit applied to `ser_in` during shift k reaches `ser_out` after shift k+7. Serial data therefore appears at `ser_out` from the eighth shift after a load onward, in the order it was applied.
- R9: Interleaved loading works: a B byte can be captured in the same cycle as, or during, an A load and its shifting. That B byte can then be loaded on a later edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset for the register; also clears the latch |
| par_a | input | WIDTH | Direct parallel byte A |
| par_b | input | WIDTH | Parallel byte B, held by the latch |
| b_open | input | 1 | Latch enable for B, transparent when high |
| sel_b | input | 1 | Load source: 0 selects A, 1 selects held B |
| load_n | input | 1 | 0 loads the parallel byte, 1 shifts |
| ser_in | input | 1 | Serial data into stage 0 |
| ser_out | output | 1 | Most significant stage |

## Verification
Every result is due one clock edge after its stimulus, because the only register between the inputs and `ser_out` is the shift register itself. A loaded bit 7 is visible right after the load edge. Bit 7-k is visible after the k-th shift, and a serial bit after seven more edges. The bench drives inputs on the falling edge and samples `ser_out` one nanosecond after each rising edge, comparing against the bit index computed for that edge count. Latch hold is checked by scrambling `par_b` before a later load from B.

// File: rtl/mlsr_pkg.sv
// Shared types for the dual-source shift register.
// Assumes: nothing beyond a standard elaborator.
package mlsr_pkg;
    localparam int DEFAULT_WIDTH = 8;

    // Operation applied to the register at the next clock edge
    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_SHIFT = 1'b1
    } op_t;
endpackage

// File: rtl/mlsr_in_latch.sv
// Transparent holding latch for parallel port B.
// Follows d while open is high, keeps its value while open is low.
// Assumes: open is stable around the clock edge; rst_n low clears it.
module mlsr_in_latch #(
    parameter int WIDTH = mlsr_pkg::DEFAULT_WIDTH
) (
    input  logic             rst_n,
    input  logic             open,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Level-sensitive capture of the B byte
    always_latch begin
        if (!rst_n) begin
            q = '0;
        end else if (open) begin
            q = d;
        end
    end
endmodule

// File: rtl/mlsr_load_mux.sv
// Per-bit 2:1 selector choosing the parallel load byte.
// Assumes: one select line steers all bits together.
module mlsr_load_mux #(
    parameter int WIDTH = mlsr_pkg::DEFAULT_WIDTH
) (
    input  logic             sel_b,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);
    // One selector cell per bit
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign y[i] = sel_b ? b[i] : a[i];
    end
endmodule

// File: rtl/mlsr_shift_core.sv
// Register stages with parallel load and shift toward the top stage.
// Stage 0 takes the serial input during a shift.
// Assumes: synchronous active-low reset, WIDTH >= 2.
module mlsr_shift_core
    import mlsr_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_t              op,
    input  logic [WIDTH-1:0] load_data,
    input  logic             ser_in,
    output logic [WIDTH-1:0] stage_q
);
    logic [WIDTH-1:0] shift_next;

    // Neighbour wiring for the shift path
    for (genvar i = 0; i < WIDTH; i++) begin : g_next
        if (i == 0) begin : g_head
            assign shift_next[i] = ser_in;
        end else begin : g_body
            assign shift_next[i] = stage_q[i-1];
        end
    end

    // Stage update: reset, load or shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (op == OP_LOAD) begin
            stage_q <= load_data;
        end else begin
            stage_q <= shift_next;
        end
    end
endmodule

// File: rtl/mlsr_top.sv
// Top level: latch on port B, source selector, shift core.
// The serial output is the most significant stage, unregistered.
// Assumes: inputs change away from the rising clock edge.
module mlsr_top
    import mlsr_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] par_a,
    input  logic [WIDTH-1:0] par_b,
    input  logic             b_open,
    input  logic             sel_b,
    input  logic             load_n,
    input  logic             ser_in,
    output logic             ser_out
);
    logic [WIDTH-1:0] b_held;
    logic [WIDTH-1:0] load_byte;
    logic [WIDTH-1:0] stage_q;
    op_t              op;

    // Decode the active-low load control into an operation
    assign op = load_n ? OP_SHIFT : OP_LOAD;

    mlsr_in_latch #(.WIDTH(WIDTH)) u_latch (
        .rst_n (rst_n),
        .open  (b_open),
        .d     (par_b),
        .q     (b_held)
    );

    mlsr_load_mux #(.WIDTH(WIDTH)) u_mux (
        .sel_b (sel_b),
        .a     (par_a),
        .b     (b_held),
        .y     (load_byte)
    );

    mlsr_shift_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .load_data (load_byte),
        .ser_in    (ser_in),
        .stage_q   (stage_q)
    );

    // Serial output taken straight from the top stage
    assign ser_out = stage_q[WIDTH-1];
endmodule

// File: rtl/mlsr_checker.sv
// Property checker for mlsr_top, attached by bind below.
// Assumes: inputs are stable across each rising edge.
module mlsr_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] par_a,
    input logic [WIDTH-1:0] par_b,
    input logic             b_open,
    input logic             sel_b,
    input logic             load_n,
    input logic             ser_in,
    input logic             ser_out,
    input logic [WIDTH-1:0] b_held,
    input logic [WIDTH-1:0] stages
);
    // R1: reset clears the output stage
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (ser_out == 1'b0));

    // R3: load from port A
    assert_load_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !sel_b) |=> (stages == $past(par_a)));

    // R4: load from the held B byte while the latch is closed
    assert_load_held_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && sel_b && !b_open) |=> (stages == $past(b_held)));

    // R5: transparent latch passes par_b straight to the load
    assert_load_open_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && sel_b && b_open) |=> (stages == $past(par_b)));

    // R6: closed latch keeps its value
    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_open && $past(!b_open) && $past(rst_n)) |-> (b_held == $past(b_held)));

    // R7: shift moves each stage up and takes ser_in at the bottom
    assert_shift_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> (stages == {$past(stages[WIDTH-2:0]), $past(ser_in)}));

    // R2: output follows the stage below after a shift
    assert_out_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> (ser_out == $past(stages[WIDTH-2])));
endmodule

bind mlsr_top mlsr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .par_a   (par_a),
    .par_b   (par_b),
    .b_open  (b_open),
    .sel_b   (sel_b),
    .load_n  (load_n),
    .ser_in  (ser_in),
    .ser_out (ser_out),
    .b_held  (b_held),
    .stages  (stage_q)
);

// File: tb/mlsr_top_tb.sv
// Directed bench for mlsr_top: one task per scenario.
module mlsr_top_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] par_a = '0;
    logic [W-1:0] par_b = '0;
    logic         b_open = 1'b0;
    logic         sel_b = 1'b0;
    logic         load_n = 1'b1;
    logic         ser_in = 1'b0;
    logic         ser_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    mlsr_top #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .par_a(par_a), .par_b(par_b),
        .b_open(b_open), .sel_b(sel_b), .load_n(load_n),
        .ser_in(ser_in), .ser_out(ser_out)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    // Advance one rising edge and settle for sampling
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Move to the falling edge before changing inputs
    task automatic to_fall();
        @(negedge clk);
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: ser_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Shift seven times after a load, checking bits 6..0 (R7)
    task automatic drain_byte(string req, logic [W-1:0] val);
        for (int k = 1; k < W; k++) begin
            to_fall();
            load_n = 1'b1;
            ser_in = 1'b0;
            par_b = ~par_b;
            tick();
            check_bit(req, ser_out, val[W-1-k]);
        end
    endtask

    // R1: reset clears the register
    task automatic test_reset();
        to_fall();
        rst_n = 1'b1; load_n = 1'b0; sel_b = 1'b0; par_a = 8'hFF;
        tick();
        to_fall();
        rst_n = 1'b0;
        tick();
        check_bit("R1 reset", ser_out, 1'b0);
        to_fall();
        rst_n = 1'b1; load_n = 1'b1; ser_in = 1'b0;
        for (int k = 0; k < W; k++) begin
            tick();
            check_bit("R1 cleared stages", ser_out, 1'b0);
            to_fall();
        end
    endtask

    // R3/R7/R8/R2: load A, shift out, then serial data follows
    task automatic test_load_a_serial(logic [W-1:0] val, logic [15:0] sbits);
        to_fall();
        load_n = 1'b0; sel_b = 1'b0; par_a = val;
        tick();
        check_bit("R3 load A msb (R2)", ser_out, val[W-1]);
        for (int k = 1; k <= 16; k++) begin
            to_fall();
            load_n = 1'b1;
            par_a = ~par_a;
            ser_in = sbits[k-1];
            tick();
            if (k < W) check_bit("R7 shift order", ser_out, val[W-1-k]);
            else       check_bit("R8 serial arrival", ser_out, sbits[k-W]);
        end
    endtask

    // R5: load from B while the latch is open
    task automatic test_load_open_b(logic [W-1:0] val);
        to_fall();
        b_open = 1'b1; par_b = val; load_n = 1'b0; sel_b = 1'b1;
        tick();
        check_bit("R5 open latch load", ser_out, val[W-1]);
        to_fall();
        b_open = 1'b0;
        drain_byte("R5 open latch byte", val);
    endtask

    // R6/R4: closed latch ignores par_b until a later load
    task automatic test_hold_b(logic [W-1:0] val);
        to_fall();
        b_open = 1'b1; par_b = val; load_n = 1'b1;
        tick();
        to_fall();
        b_open = 1'b0; par_b = ~val;
        tick();
        to_fall();
        par_b = 8'h5A ^ val;
        tick();
        to_fall();
        load_n = 1'b0; sel_b = 1'b1; par_b = ~val;
        tick();
        check_bit("R6 hold / R4 load B msb", ser_out, val[W-1]);
        drain_byte("R4 held B byte", val);
    endtask

    // R9: capture B during an A load, load B afterwards
    task automatic test_interleave(logic [W-1:0] va, logic [W-1:0] vb);
        to_fall();
        load_n = 1'b0; sel_b = 1'b0; par_a = va;
        b_open = 1'b1; par_b = vb;
        tick();
        check_bit("R9 A loaded", ser_out, va[W-1]);
        to_fall();
        b_open = 1'b0;
        drain_byte("R9 A byte", va);
        to_fall();
        load_n = 1'b0; sel_b = 1'b1; par_a = ~vb; par_b = ~vb;
        tick();
        check_bit("R9 B loaded", ser_out, vb[W-1]);
        drain_byte("R9 B byte", vb);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        test_reset();
        test_load_a_serial(8'hB4, 16'hC3A5);
        test_load_a_serial(8'h01, 16'h00FF);
        test_load_open_b(8'h96);
        test_hold_b(8'hD2);
        test_hold_b(8'h2D);
        test_interleave(8'hE1, 8'h3C);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule